// File: doc/BRIEF.md
# Local Bitmap Must-Repair Analyzer

This block sits beside a memory under self-test and gathers the failing cells reported by the test engine into a small local fault bitmap. It does not use a full-size fault map. The bitmap has a handful of row slots, each holding a failing row address, and a handful of column slots, each holding a failing column address. A matrix of fault bits marks which stored row and stored column meet at a failing cell. A new failing address takes the lowest free slot. An address already held reuses its slot.

While failures stream in, the block runs the must-repair phase of two-dimensional spare allocation. A row is forced onto a spare row when its fault count exceeds the spare columns left. A column is forced onto a spare column when its fault count exceeds the spare rows left. Each forced repair is reported with its address, its slot and fault bits are wiped, and the matching spare budget drops by one. If a forced repair needs a spare of a kind that has run out, the memory is flagged unrepairable. When the bitmap has no room for a new failure, or the test ends, the block freezes its contents. Once no forced repair is pending, it raises a hand-off strobe so that a final-repair stage can read the bitmap.

Top module: `lbm_must_repair`

## Requirements
- R1: While reset is low, and in the cycle after `start_i`, the bitmap is empty (all slot valid bits and fault bits 0) and all flags are low. Reset loads both spare budgets with 0. `start_i` loads them from `spare_row_i` and `spare_col_i`.
- R2: An accepted failure whose row or column address is not yet stored goes into the lowest-numbered free slot of that kind. A stored address reuses its slot. The fault bit at index `row_slot*COLS + col_slot` of `map_bits_o` is set on the clock edge that samples `fail_i`.
- R3: A row whose fault count exceeds the spare columns left, while at least one spare row is left, is repaired on the next edge. On that edge its slot and fault bits are cleared and `rows_left_o` drops by one. `rrep_o` is high for exactly the following cycle, with the row address on `rrep_addr_o`.
- R4: A column whose fault count exceeds the spare rows left, while at least one spare column is left and no row is forced, is repaired in the same way. It is reported on `crep_o` / `crep_addr_o`, and `cols_left_o` drops by one.
- R5: At most one repair is made per cycle. A forced row takes precedence over a forced column. Among forced rows, or among forced columns, the lowest slot goes first.
- R6: A forced repair whose spare budget is 0 sets `unrep_o` on the next edge. It stays set until `start_i`. While it is set, no repair is made and failures leave the bitmap unchanged.
- R7: `full_o` is high whenever every row slot or every column slot holds an address.
- R8: A failure that needs a new slot when none of that kind is free is not recorded, and it freezes the analysis. From then on, failures are ignored, and `handoff_o` is high whenever no forced repair is pending and `unrep_o` is low.
- R9: A pulse on `test_done_i` freezes the analysis in the same way. Forced repairs still pending are finished first, and `handoff_o` stays low until they are.
- R10: A failure arriving on the edge that repairs its row or its column is dropped (the spare covers it). Any other failure on that edge is recorded, but it cannot take the slot being freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new analysis: clear bitmap, load spare budgets |
| spare_row_i | input | SPW | Spare rows available, loaded on start |
| spare_col_i | input | SPW | Spare columns available, loaded on start |
| fail_i | input | 1 | Failing cell strobe from the test engine |
| fail_row_i | input | RAW | Row address of the failing cell |
| fail_col_i | input | CAW | Column address of the failing cell |
| test_done_i | input | 1 | Test sequence finished |
| rrep_o | output | 1 | One-cycle strobe: a row was forced onto a spare row |
| rrep_addr_o | output | RAW | Address of the repaired row |
| crep_o | output | 1 | One-cycle strobe: a column was forced onto a spare column |
| crep_addr_o | output | CAW | Address of the repaired column |
| rows_left_o | output | SPW | Spare rows still unused |
| cols_left_o | output | SPW | Spare columns still unused |
| full_o | output | 1 | All row slots or all column slots occupied |
| unrep_o | output | 1 | Sticky: a forced repair found its spare budget empty |
| handoff_o | output | 1 | Bitmap frozen and free of forced repairs, ready for final repair |
| map_row_vld_o | output | ROWS | Valid bit of each row slot |
| map_row_addr_o | output | ROWS*RAW | Row slot addresses, slot i at bits i*RAW |
| map_col_vld_o | output | COLS | Valid bit of each column slot |
| map_col_addr_o | output | CAW*COLS | Column slot addresses, slot j at bits j*CAW |
| map_bits_o | output | ROWS*COLS | Fault bits, bit r*COLS+c for row slot r, column slot c |

## Verification
Two functions can act on the same clock edge: a forced repair clearing a slot, and the recording of a fresh failure. The bench provokes this by issuing failures on back-to-back cycles with the spare-column budget at zero, so that the first failure forces its row just as the second arrives. In one case the second failure shares the repaired row, and the bench expects it to vanish with that row. In the other case it lies in another row, and the bench expects it in the next free slot, not the slot being vacated, and expects it to be forced in the following cycle. A second clash pairs `test_done_i` with a failure that forces a repair, and the bench checks that `handoff_o` waits one cycle for that repair.

// File: rtl/lbm_pkg.sv
`timescale 1ns/1ps
// Shared types for the local-bitmap must-repair analyzer.
package lbm_pkg;

    // Action decided by the must-repair rules in one cycle.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_ROW   = 2'd1,
        ACT_COL   = 2'd2,
        ACT_STUCK = 2'd3
    } lbm_act_e;

endpackage

// File: rtl/lbm_addr_tags.sv
`timescale 1ns/1ps
// Address slot file: N slots, each a valid bit and an AW-bit address.
// Looks up an address (lowest matching slot) and offers the lowest free slot.
// Assumes the caller never allocates when free_ok is low and never drops and
// allocates the same slot in one cycle (a dropped slot is valid, a free one is not).
module lbm_addr_tags #(
    parameter  int N  = 4,
    parameter  int AW = 10,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_all,
    input  logic [AW-1:0]   look_addr,
    input  logic            alloc_en,
    input  logic            drop_en,
    input  logic [IW-1:0]   drop_idx,
    output logic            hit,
    output logic [IW-1:0]   hit_idx,
    output logic            free_ok,
    output logic [IW-1:0]   free_idx,
    output logic [N-1:0]    vld,
    output logic [N*AW-1:0] addr_flat
);

    logic [N-1:0]  vld_q;
    logic [AW-1:0] addr_q [N];

    // Match and free-slot search; descending loop leaves the lowest index.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld_q[i] && (addr_q[i] == look_addr)) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!vld_q[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // Slot state: clear, drop a repaired slot, or fill the free slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) begin
                addr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (drop_en && (drop_idx == IW'(i))) begin
                    vld_q[i] <= 1'b0;
                end else if (alloc_en && (free_idx == IW'(i))) begin
                    vld_q[i]  <= 1'b1;
                    addr_q[i] <= look_addr;
                end
            end
        end
    end

    assign vld = vld_q;

    // Flatten slot addresses for the bitmap read-out.
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign addr_flat[g*AW +: AW] = addr_q[g];
    end

endmodule

// File: rtl/lbm_force_pick.sv
`timescale 1ns/1ps
// Must-repair rule for one direction: among N bit lines of M bits each,
// flags any line with more set bits than `limit` and returns the lowest such line.
// Purely combinational; assumes M fits comfortably in an int count.
module lbm_force_pick #(
    parameter  int N  = 4,
    parameter  int M  = 5,
    parameter  int LW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*M-1:0] lines_flat,
    input  logic [LW-1:0]  limit,
    output logic           force_o,
    output logic [IW-1:0]  idx_o
);

    // Count each line and keep the lowest one over the limit.
    always_comb begin
        force_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if ($countones(lines_flat[i*M +: M]) > int'(limit)) begin
                force_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lbm_must_repair.sv
`timescale 1ns/1ps
// Local-bitmap must-repair analyzer.
// Collects failing cells into a ROWS x COLS fault bitmap with address slots,
// applies the row-must / column-must rules against the remaining spare budgets
// (one repair per cycle, rows first), and freezes for a final-repair stage on
// overflow or end of test. Assumes the test engine reports at most one failing
// cell per cycle and that start_i is pulsed before each analysis.
module lbm_must_repair #(
    parameter  int ROWS = 4,
    parameter  int COLS = 5,
    parameter  int RAW  = 10,
    parameter  int CAW  = 7,
    parameter  int SPW  = 3,
    localparam int RIW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CIW  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int NB   = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SPW-1:0]    spare_row_i,
    input  logic [SPW-1:0]    spare_col_i,
    input  logic              fail_i,
    input  logic [RAW-1:0]    fail_row_i,
    input  logic [CAW-1:0]    fail_col_i,
    input  logic              test_done_i,
    output logic              rrep_o,
    output logic [RAW-1:0]    rrep_addr_o,
    output logic              crep_o,
    output logic [CAW-1:0]    crep_addr_o,
    output logic [SPW-1:0]    rows_left_o,
    output logic [SPW-1:0]    cols_left_o,
    output logic              full_o,
    output logic              unrep_o,
    output logic              handoff_o,
    output logic [ROWS-1:0]   map_row_vld_o,
    output logic [ROWS*RAW-1:0] map_row_addr_o,
    output logic [COLS-1:0]   map_col_vld_o,
    output logic [COLS*CAW-1:0] map_col_addr_o,
    output logic [NB-1:0]     map_bits_o
);
    import lbm_pkg::*;

    logic [NB-1:0]  bits_q;
    logic [NB-1:0]  col_lines;
    logic [NB-1:0]  clr_mask;
    logic [NB-1:0]  set_mask;
    logic [SPW-1:0] rows_left_q;
    logic [SPW-1:0] cols_left_q;
    logic           unrep_q;
    logic           frozen_q;
    logic           rrep_q;
    logic           crep_q;
    logic [RAW-1:0] rrep_addr_q;
    logic [CAW-1:0] crep_addr_q;

    logic           r_hit, r_free, c_hit, c_free;
    logic [RIW-1:0] r_hit_idx, r_free_idx, r_tgt;
    logic [CIW-1:0] c_hit_idx, c_free_idx, c_tgt;
    logic           rf_hit, cf_hit;
    logic [RIW-1:0] rf_idx;
    logic [CIW-1:0] cf_idx;
    lbm_act_e       act;
    logic           accept, dropped, overflow, rec_en;

    // Row and column slot files.
    lbm_addr_tags #(.N(ROWS), .AW(RAW)) u_row_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (start_i),
        .look_addr (fail_row_i),
        .alloc_en  (rec_en && !r_hit),
        .drop_en   (act == ACT_ROW),
        .drop_idx  (rf_idx),
        .hit       (r_hit),
        .hit_idx   (r_hit_idx),
        .free_ok   (r_free),
        .free_idx  (r_free_idx),
        .vld       (map_row_vld_o),
        .addr_flat (map_row_addr_o)
    );

    lbm_addr_tags #(.N(COLS), .AW(CAW)) u_col_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (start_i),
        .look_addr (fail_col_i),
        .alloc_en  (rec_en && !c_hit),
        .drop_en   (act == ACT_COL),
        .drop_idx  (cf_idx),
        .hit       (c_hit),
        .hit_idx   (c_hit_idx),
        .free_ok   (c_free),
        .free_idx  (c_free_idx),
        .vld       (map_col_vld_o),
        .addr_flat (map_col_addr_o)
    );

    // Column view of the bitmap: column c occupies bits c*ROWS .. c*ROWS+ROWS-1.
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_tr_r
        for (genvar gc = 0; gc < COLS; gc++) begin : g_tr_c
            assign col_lines[gc*ROWS + gr] = bits_q[gr*COLS + gc];
        end
    end

    // Must-repair rules: rows against spare columns, columns against spare rows.
    lbm_force_pick #(.N(ROWS), .M(COLS), .LW(SPW)) u_row_rule (
        .lines_flat (bits_q),
        .limit      (cols_left_q),
        .force_o    (rf_hit),
        .idx_o      (rf_idx)
    );

    lbm_force_pick #(.N(COLS), .M(ROWS), .LW(SPW)) u_col_rule (
        .lines_flat (col_lines),
        .limit      (rows_left_q),
        .force_o    (cf_hit),
        .idx_o      (cf_idx)
    );

    // Pick this cycle's action: row rule first, empty budget means stuck.
    always_comb begin
        act = ACT_NONE;
        if (!unrep_q && !start_i) begin
            if (rf_hit) begin
                act = (rows_left_q == '0) ? ACT_STUCK : ACT_ROW;
            end else if (cf_hit) begin
                act = (cols_left_q == '0) ? ACT_STUCK : ACT_COL;
            end
        end
    end

    // Failure intake: drop if covered by this cycle's repair, else record or overflow.
    always_comb begin
        accept   = fail_i && !frozen_q && !unrep_q && !start_i;
        dropped  = ((act == ACT_ROW) && r_hit && (r_hit_idx == rf_idx)) ||
                   ((act == ACT_COL) && c_hit && (c_hit_idx == cf_idx));
        overflow = accept && !dropped &&
                   ((!r_hit && !r_free) || (!c_hit && !c_free));
        rec_en   = accept && !dropped && !overflow;
        r_tgt    = r_hit ? r_hit_idx : r_free_idx;
        c_tgt    = c_hit ? c_hit_idx : c_free_idx;
    end

    // Bit masks: wipe the repaired line, set the newly recorded cell.
    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if ((act == ACT_ROW) && (rf_idx == RIW'(r))) clr_mask[r*COLS + c] = 1'b1;
                if ((act == ACT_COL) && (cf_idx == CIW'(c))) clr_mask[r*COLS + c] = 1'b1;
                if (rec_en && (r_tgt == RIW'(r)) && (c_tgt == CIW'(c))) set_mask[r*COLS + c] = 1'b1;
            end
        end
    end

    // Bitmap, spare budgets, sticky flags and repair strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q      <= '0;
            rows_left_q <= '0;
            cols_left_q <= '0;
            unrep_q     <= 1'b0;
            frozen_q    <= 1'b0;
            rrep_q      <= 1'b0;
            crep_q      <= 1'b0;
            rrep_addr_q <= '0;
            crep_addr_q <= '0;
        end else if (start_i) begin
            bits_q      <= '0;
            rows_left_q <= spare_row_i;
            cols_left_q <= spare_col_i;
            unrep_q     <= 1'b0;
            frozen_q    <= 1'b0;
            rrep_q      <= 1'b0;
            crep_q      <= 1'b0;
        end else begin
            bits_q <= (bits_q & ~clr_mask) | set_mask;
            rrep_q <= (act == ACT_ROW);
            crep_q <= (act == ACT_COL);
            if (act == ACT_ROW) begin
                rows_left_q <= rows_left_q - 1'b1;
                rrep_addr_q <= map_row_addr_o[rf_idx*RAW +: RAW];
            end
            if (act == ACT_COL) begin
                cols_left_q <= cols_left_q - 1'b1;
                crep_addr_q <= map_col_addr_o[cf_idx*CAW +: CAW];
            end
            if (act == ACT_STUCK) unrep_q <= 1'b1;
            if (test_done_i || overflow) frozen_q <= 1'b1;
        end
    end

    assign rrep_o      = rrep_q;
    assign crep_o      = crep_q;
    assign rrep_addr_o = rrep_addr_q;
    assign crep_addr_o = crep_addr_q;
    assign rows_left_o = rows_left_q;
    assign cols_left_o = cols_left_q;
    assign unrep_o     = unrep_q;
    assign map_bits_o  = bits_q;
    assign full_o      = (&map_row_vld_o) || (&map_col_vld_o);
    assign handoff_o   = frozen_q && !rf_hit && !cf_hit && !unrep_q;

endmodule

// File: rtl/lbm_checks.sv
`timescale 1ns/1ps
// Property checker for lbm_must_repair, attached by bind below.
module lbm_checks #(
    parameter int ROWS = 4,
    parameter int COLS = 5,
    parameter int RAW  = 10,
    parameter int CAW  = 7,
    parameter int SPW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [SPW-1:0]    spare_row_i,
    input logic [SPW-1:0]    spare_col_i,
    input logic              fail_i,
    input logic [RAW-1:0]    fail_row_i,
    input logic [CAW-1:0]    fail_col_i,
    input logic              test_done_i,
    input logic              rrep_o,
    input logic [RAW-1:0]    rrep_addr_o,
    input logic              crep_o,
    input logic [CAW-1:0]    crep_addr_o,
    input logic [SPW-1:0]    rows_left_o,
    input logic [SPW-1:0]    cols_left_o,
    input logic              full_o,
    input logic              unrep_o,
    input logic              handoff_o,
    input logic [ROWS-1:0]   map_row_vld_o,
    input logic [ROWS*RAW-1:0] map_row_addr_o,
    input logic [COLS-1:0]   map_col_vld_o,
    input logic [COLS*CAW-1:0] map_col_addr_o,
    input logic [ROWS*COLS-1:0] map_bits_o
);

    // R1: a start leaves an empty bitmap and clear flags
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (map_bits_o == '0 && map_row_vld_o == '0 && !unrep_o && !handoff_o));

    // R3: a row strobe coincides with the spare-row budget having just dropped by one
    assert_row_spend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rrep_o |-> (rows_left_o == $past(rows_left_o) - 1'b1));

    // R4: a column strobe coincides with the spare-column budget having just dropped
    assert_col_spend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crep_o |-> (cols_left_o == $past(cols_left_o) - 1'b1));

    // R5: never two repairs at once
    assert_single_repair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rrep_o && crep_o));

    // R6: unrepairable is sticky and freezes the bitmap
    assert_stuck_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (unrep_o && !start_i) |=> (unrep_o && $stable(map_bits_o)));

    // R8: hand-off is never offered for an unrepairable memory
    assert_handoff_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |-> !unrep_o);

endmodule

bind lbm_must_repair lbm_checks #(
    .ROWS(ROWS), .COLS(COLS), .RAW(RAW), .CAW(CAW), .SPW(SPW)
) u_lbm_checks (.*);

// File: tb/tb_lbm_must_repair.sv
`timescale 1ns/1ps
module tb_lbm_must_repair;

    localparam int ROWS = 4, COLS = 5, RAW = 10, CAW = 7, SPW = 3;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, fail_i = 1'b0, test_done_i = 1'b0;
    logic [SPW-1:0] spare_row_i = '0, spare_col_i = '0;
    logic [RAW-1:0] fail_row_i = '0;
    logic [CAW-1:0] fail_col_i = '0;
    logic rrep_o, crep_o, full_o, unrep_o, handoff_o;
    logic [RAW-1:0] rrep_addr_o;
    logic [CAW-1:0] crep_addr_o;
    logic [SPW-1:0] rows_left_o, cols_left_o;
    logic [ROWS-1:0] map_row_vld_o;
    logic [ROWS*RAW-1:0] map_row_addr_o;
    logic [COLS-1:0] map_col_vld_o;
    logic [COLS*CAW-1:0] map_col_addr_o;
    logic [ROWS*COLS-1:0] map_bits_o;

    int n_run = 0, n_fail = 0, r_cnt = 0, c_cnt = 0;
    logic [RAW-1:0] r_last = '0;
    logic [CAW-1:0] c_last = '0;
    bit finished = 1'b0;

    lbm_must_repair #(.ROWS(ROWS), .COLS(COLS), .RAW(RAW), .CAW(CAW), .SPW(SPW)) dut (.*);

    always #2.5 clk = ~clk;

    // Repair strobe monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (start_i) begin
            r_cnt = 0; c_cnt = 0;
        end else begin
            if (rrep_o) begin r_cnt++; r_last = rrep_addr_o; end
            if (crep_o) begin c_cnt++; c_last = crep_addr_o; end
        end
    end

    // Vector: spare rows, spare cols, row, col, exp row rep, exp col rep, exp unrep, exp rows left
    localparam int VW = SPW + SPW + RAW + CAW + 3 + SPW;
    localparam logic [VW-1:0] VEC [6] = '{
        {3'd1, 3'd1, 10'd12,   7'd5,   1'b0, 1'b0, 1'b0, 3'd1},
        {3'd1, 3'd0, 10'd12,   7'd5,   1'b1, 1'b0, 1'b0, 3'd0},
        {3'd0, 3'd1, 10'd40,   7'd9,   1'b0, 1'b1, 1'b0, 3'd0},
        {3'd0, 3'd0, 10'd3,    7'd3,   1'b0, 1'b0, 1'b1, 3'd0},
        {3'd2, 3'd0, 10'd100,  7'd2,   1'b1, 1'b0, 1'b0, 3'd1},
        {3'd3, 3'd3, 10'd1023, 7'd127, 1'b0, 1'b0, 1'b0, 3'd3}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic go(input int sr, input int sc);
        start_i = 1'b1; spare_row_i = SPW'(sr); spare_col_i = SPW'(sc);
        cyc();
        start_i = 1'b0;
    endtask

    task automatic put(input int r, input int c);
        fail_i = 1'b1; fail_row_i = RAW'(r); fail_col_i = CAW'(c);
        cyc();
        fail_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        @(negedge clk);
        // R1: reset state
        chk("R1 reset", {map_bits_o, map_row_vld_o, map_col_vld_o, rows_left_o, cols_left_o,
                         unrep_o, handoff_o, full_o, rrep_o, crep_o}, '0);
        @(posedge clk); #1; rst_n = 1'b1;

        // Table walk: single failure against several spare budgets (R3, R4, R6)
        for (int k = 0; k < 6; k++) begin
            logic [VW-1:0] v;
            v = VEC[k];
            go(int'(v[VW-1 -: SPW]), int'(v[VW-SPW-1 -: SPW]));
            put(int'(v[CAW+6 +: RAW]), int'(v[6 +: CAW]));
            repeat (3) cyc();
            @(negedge clk);
            chk("R3/R4/R6 table", {r_cnt[3:0], c_cnt[3:0], unrep_o, rows_left_o},
                {3'b000, v[5], 3'b000, v[4], v[3], v[2:0]});
        end

        // R2: slot allocation and bit placement
        go(2, 2);
        chk("R1 budgets loaded", {rows_left_o, cols_left_o}, {3'd2, 3'd2});
        put(5, 3); put(5, 4); put(9, 3);
        @(negedge clk);
        chk("R2 bits", map_bits_o, 20'h00023);
        chk("R2 slots", {map_row_vld_o, map_col_vld_o, map_row_addr_o[19:0], map_col_addr_o[13:0]},
            {4'b0011, 5'b00011, 10'd9, 10'd5, 7'd4, 7'd3});
        // R3: row with three faults exceeds two spare columns
        put(5, 7);
        @(negedge clk);
        chk("R3 not before clearing edge", rrep_o, 1'b0);
        cyc(); @(negedge clk);
        chk("R3 row strobe", {rrep_o, rrep_addr_o, rows_left_o, map_row_vld_o, map_bits_o},
            {1'b1, 10'd5, 3'd1, 4'b0010, 20'h00020});
        cyc(); @(negedge clk);
        chk("R3 one-cycle strobe", rrep_o, 1'b0);
        // R4: column 3 now holds two faults against one spare row
        put(11, 3);
        cyc(); @(negedge clk);
        chk("R4 column strobe", {crep_o, crep_addr_o, cols_left_o, map_col_vld_o, map_bits_o},
            {1'b1, 7'd3, 3'd1, 5'b00110, 20'h0});

        // R5: row and column forced together, row goes first
        go(1, 1);
        put(1, 1); put(2, 2); put(1, 2);
        cyc(); @(negedge clk);
        chk("R5 row first", {rrep_o, rrep_addr_o, crep_o}, {1'b1, 10'd1, 1'b0});
        cyc(); @(negedge clk);
        chk("R5 column next", {crep_o, crep_addr_o, rrep_o, unrep_o, map_bits_o},
            {1'b1, 7'd2, 1'b0, 1'b0, 20'h0});

        // R10: failure in the row being repaired is dropped
        go(2, 0);
        put(7, 1); put(7, 3);
        @(negedge clk);
        chk("R10 dropped", {rrep_o, rrep_addr_o, map_row_vld_o, map_col_vld_o, map_bits_o},
            {1'b1, 10'd7, 4'b0000, 5'b00001, 20'h0});
        cyc(); @(negedge clk);
        chk("R10 no second repair", {r_cnt[3:0], rows_left_o}, {4'd1, 3'd1});
        // R10: failure elsewhere lands in next free slot, not the freed one
        go(2, 0);
        put(7, 1); put(9, 2);
        @(negedge clk);
        chk("R10 recorded elsewhere", {rrep_addr_o, map_row_vld_o, map_bits_o},
            {10'd7, 4'b0010, 20'h00040});
        cyc(); @(negedge clk);
        chk("R10 later forced", {rrep_o, rrep_addr_o}, {1'b1, 10'd9});

        // R7 / R8: fill row slots, then overflow
        go(7, 7);
        put(1, 0); put(2, 0); put(3, 0);
        @(negedge clk);
        chk("R7 not full", full_o, 1'b0);
        put(4, 0);
        @(negedge clk);
        chk("R7 full", full_o, 1'b1);
        put(5, 0);
        @(negedge clk);
        chk("R8 overflow handoff", {handoff_o, map_row_vld_o, map_bits_o},
            {1'b1, 4'b1111, 20'h08421});
        put(1, 1);
        @(negedge clk);
        chk("R8 frozen", {map_col_vld_o, map_bits_o}, {5'b00001, 20'h08421});

        // R9: test end coinciding with a forcing failure
        go(1, 0);
        fail_i = 1'b1; test_done_i = 1'b1; fail_row_i = 10'd3; fail_col_i = 7'd3;
        cyc();
        fail_i = 1'b0; test_done_i = 1'b0;
        @(negedge clk);
        chk("R9 handoff waits", handoff_o, 1'b0);
        cyc(); @(negedge clk);
        chk("R9 handoff after repair", {handoff_o, rrep_o, map_bits_o}, {1'b1, 1'b1, 20'h0});

        // R6: empty budgets make the first failure unrepairable
        go(0, 0);
        put(6, 6);
        cyc(); @(negedge clk);
        chk("R6 stuck", {unrep_o, map_row_vld_o, r_cnt[3:0]}, {1'b1, 4'b0001, 4'd0});
        put(8, 8);
        test_done_i = 1'b1; cyc(); test_done_i = 1'b0;
        @(negedge clk);
        chk("R6 ignored after stuck", {map_row_vld_o, map_bits_o, handoff_o, unrep_o},
            {4'b0001, 20'h00001, 1'b0, 1'b1});

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule